// File: doc/BRIEF.md
# Phase-Accumulator PWM Generator

This block produces one pulse-width-modulated output whose rate is set by a fractional phase step rather than an integer terminal count. On every enabled clock a 16-bit step value is added to a 16-bit phase accumulator. The output rate is therefore the clock rate times step / 65536. The output is high while the accumulator's top eight bits are at or above an 8-bit threshold, so the duty fraction is roughly (255 - threshold) / 255. A larger threshold gives a shorter high time.

Software controls the block through one 32-bit control word on a plain write port, and the same word can be read back at any time. The step and threshold fields are staged and do not act at once. Software writes them together with a commit flag, and the working copies pick up the staged values at the next period boundary, which is the cycle the accumulator carries out. If the generator is stopped, the working copies pick up the staged values on the next clock. The commit flag clears itself when the copy is taken. Clearing the run bit forces the output low and holds the phase at zero, and counting restarts from zero when the run bit is set again.

Top module: `phase_pwm`

## Requirements
- R1: After reset the read word is 0x00000000, the output is low and the accumulator is zero.
- R2: A write stores the run bit (bit 31), the commit flag (bit 30), the 16-bit step (bits 23:8) and the 8-bit threshold (bits 7:0), and these bits read back as written. Bits 29:24 always read zero.
- R3: While running, the working step and threshold change only on a cycle where the accumulator carries out while the commit flag is set. A write without the commit flag leaves the output waveform unchanged.
- R4: The commit flag reads 1 from its write until the working copies load, then reads 0 with no further write.
- R5: While stopped, a set commit flag loads the working copies on the next clock.
- R6: While running, the accumulator advances by the working step each clock, modulo 65536. The output period is 65536/step cycles, for example 4 cycles for step 0x4000 and 2 cycles for step 0x8000.
- R7: While running, the output is high exactly when accumulator bits 15:8 are greater than or equal to the working threshold. A threshold of 0 keeps the output high.
- R8: While stopped, the output is low and the accumulator is held at zero. Setting the run bit starts the phase from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Writes wr_data into the control word on this clock |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Current control word |
| pwm_out | output | 1 | Modulated output |

## Verification
The bench builds the block with its default parameters: a 16-bit accumulator, an 8-bit threshold and a two-stage reset synchroniser. With these widths, steps of 0x4000 and 0x8000 give periods of four and two cycles. That lets short windows count exact high times and rising edges, and it places the deferred commit within a few cycles of its write. Threshold 0 and step 0x8002, which sits just past half the clock rate, exercise the always-high case and an accumulator that wraps on a non-integer period.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int CTRL_W    = 32;
  localparam int RUN_POS   = 31;
  localparam int COMMIT_POS = 30;
  localparam int DEF_ACC_W = 16;
  localparam int DEF_THR_W = 8;
endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pwm_ctrl_reg.sv
module pwm_ctrl_reg
  import pwm_pkg::*;
#(
  parameter int ACC_W = DEF_ACC_W,
  parameter int THR_W = DEF_THR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              load_i,
  output logic              run_o,
  output logic              commit_o,
  output logic [ACC_W-1:0]  step_o,
  output logic [THR_W-1:0]  thr_o,
  output logic [CTRL_W-1:0] rd_data_o
);
  localparam int STEP_LSB = THR_W;
  localparam int STEP_MSB = THR_W + ACC_W - 1;

  logic             run_q, run_d;
  logic             commit_q, commit_d;
  logic [ACC_W-1:0] step_q, step_d;
  logic [THR_W-1:0] thr_q, thr_d;
  logic             reg_ce;
  logic             rsvd_unused;

  assign rsvd_unused = ^wr_data[COMMIT_POS-1:STEP_MSB+1];
  assign reg_ce = wr_en | load_i;

  always_comb begin
    run_d    = run_q;
    commit_d = commit_q;
    step_d   = step_q;
    thr_d    = thr_q;
    if (wr_en) begin
      run_d    = wr_data[RUN_POS];
      commit_d = wr_data[COMMIT_POS];
      step_d   = wr_data[STEP_MSB:STEP_LSB];
      thr_d    = wr_data[THR_W-1:0];
    end else if (load_i) begin
      commit_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      commit_q <= 1'b0;
      step_q   <= '0;
      thr_q    <= '0;
    end else if (reg_ce) begin
      run_q    <= run_d;
      commit_q <= commit_d;
      step_q   <= step_d;
      thr_q    <= thr_d;
    end
  end

  always_comb begin
    rd_data_o                    = '0;
    rd_data_o[RUN_POS]           = run_q;
    rd_data_o[COMMIT_POS]        = commit_q;
    rd_data_o[STEP_MSB:STEP_LSB] = step_q;
    rd_data_o[THR_W-1:0]         = thr_q;
  end

  assign run_o    = run_q;
  assign commit_o = commit_q;
  assign step_o   = step_q;
  assign thr_o    = thr_q;
endmodule

// File: rtl/pwm_shadow.sv
module pwm_shadow #(
  parameter int ACC_W = 16,
  parameter int THR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [ACC_W-1:0] step_i,
  input  logic [THR_W-1:0] thr_i,
  output logic [ACC_W-1:0] step_o,
  output logic [THR_W-1:0] thr_o
);
  logic [ACC_W-1:0] step_q, step_d;
  logic [THR_W-1:0] thr_q, thr_d;

  always_comb begin
    step_d = step_q;
    thr_d  = thr_q;
    if (load_i) begin
      step_d = step_i;
      thr_d  = thr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      thr_q  <= '0;
    end else if (load_i) begin
      step_q <= step_d;
      thr_q  <= thr_d;
    end
  end

  assign step_o = step_q;
  assign thr_o  = thr_q;
endmodule

// File: rtl/pwm_phase_acc.sv
module pwm_phase_acc #(
  parameter int ACC_W = 16,
  parameter int THR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [ACC_W-1:0] step_i,
  input  logic [THR_W-1:0] thr_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             wrap_o,
  output logic             pwm_o
);
  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W:0]   sum;
  logic [THR_W-1:0] phase_hi;
  logic             acc_ce;

  assign sum      = {1'b0, acc_q} + {1'b0, step_i};
  assign wrap_o   = run_i & sum[ACC_W];
  assign acc_ce   = run_i | (acc_q != '0);
  assign phase_hi = acc_q[ACC_W-1 -: THR_W];

  always_comb begin
    if (run_i) acc_d = sum[ACC_W-1:0];
    else       acc_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_ce) acc_q <= acc_d;
  end

  assign pwm_o = run_i & (phase_hi >= thr_i);
  assign acc_o = acc_q;
endmodule

// File: rtl/phase_pwm.sv
module phase_pwm
  import pwm_pkg::*;
#(
  parameter int ACC_W       = DEF_ACC_W,
  parameter int THR_W       = DEF_THR_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] rd_data,
  output logic              pwm_out
);
  logic             rst_sync_n;
  logic             ctl_run, ctl_commit;
  logic [ACC_W-1:0] ctl_step, act_step, acc_q;
  logic [THR_W-1:0] ctl_thr, act_thr;
  logic             wrap, load;

  pwm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  pwm_ctrl_reg #(.ACC_W(ACC_W), .THR_W(THR_W)) u_reg (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_data(wr_data),
    .load_i(load), .run_o(ctl_run), .commit_o(ctl_commit),
    .step_o(ctl_step), .thr_o(ctl_thr), .rd_data_o(rd_data)
  );

  assign load = ctl_commit & (~ctl_run | wrap);

  pwm_shadow #(.ACC_W(ACC_W), .THR_W(THR_W)) u_shadow (
    .clk(clk), .rst_n(rst_sync_n), .load_i(load),
    .step_i(ctl_step), .thr_i(ctl_thr),
    .step_o(act_step), .thr_o(act_thr)
  );

  pwm_phase_acc #(.ACC_W(ACC_W), .THR_W(THR_W)) u_acc (
    .clk(clk), .rst_n(rst_sync_n), .run_i(ctl_run),
    .step_i(act_step), .thr_i(act_thr),
    .acc_o(acc_q), .wrap_o(wrap), .pwm_o(pwm_out)
  );
endmodule

// File: rtl/phase_pwm_chk.sv
module phase_pwm_chk #(
  parameter int ACC_W = 16,
  parameter int THR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             run,
  input logic             commit,
  input logic             wrap,
  input logic [ACC_W-1:0] ctl_step,
  input logic [ACC_W-1:0] act_step,
  input logic [THR_W-1:0] act_thr,
  input logic [ACC_W-1:0] acc,
  input logic             pwm_out
);
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !(commit && wrap)) |=> ($stable(act_step) && $stable(act_thr))); // R3

  AST_COMMIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (run && commit && wrap && !wr_en) |=> !commit); // R4

  AST_IDLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && commit && !wr_en) |=> (act_step == $past(ctl_step) && !commit)); // R5

  AST_PHASE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap && act_step != '0) |=> (acc > $past(acc))); // R6

  AST_FULL_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (run && act_thr == '0) |-> pwm_out); // R7

  AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_en) |=> (acc == '0 && !pwm_out)); // R8
endmodule

bind phase_pwm phase_pwm_chk #(.ACC_W(ACC_W), .THR_W(THR_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .run(ctl_run),
  .commit(ctl_commit), .wrap(wrap), .ctl_step(ctl_step),
  .act_step(act_step), .act_thr(act_thr), .acc(acc_q), .pwm_out(pwm_out)
);

// File: tb/tb_phase_pwm.sv
module tb_phase_pwm;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        pwm_out;

  phase_pwm dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pwm_out(pwm_out)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // behavioural reference state
  bit m_run, m_commit;
  int m_step, m_thr, a_step, a_thr, m_acc;

  function automatic logic exp_out();
    return (m_run && ((m_acc >> 8) >= a_thr)) ? 1'b1 : 1'b0;
  endfunction

  function automatic logic [31:0] exp_rd();
    logic [31:0] v;
    v = 32'h0;
    v[31] = m_run;
    v[30] = m_commit;
    v[23:8] = m_step[15:0];
    v[7:0] = m_thr[7:0];
    return v;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_step(bit we, logic [31:0] d);
    int sum;
    bit w, ld;
    sum = m_acc + a_step;
    w = m_run && (sum >= 65536);
    ld = m_commit && (!m_run || w);
    m_acc = m_run ? (sum % 65536) : 0;
    if (ld) begin a_step = m_step; a_thr = m_thr; end
    if (we) begin
      m_run = d[31]; m_commit = d[30];
      m_step = int'(d[23:8]); m_thr = int'(d[7:0]);
    end else if (ld) m_commit = 1'b0;
  endtask

  task automatic cycle(bit we, logic [31:0] d);
    wr_en = we;
    wr_data = d;
    @(posedge clk);
    model_step(we, d);
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = 32'h0;
    check("R7 model output", {31'h0, pwm_out}, {31'h0, exp_out()});
    check("R2 model readback", rd_data, exp_rd());
  endtask

  // idle cycles, counting high samples and rising edges
  task automatic run_count(int n, output int highs, output int rises);
    logic prev;
    prev = pwm_out;
    highs = 0;
    rises = 0;
    for (int i = 0; i < n; i++) begin
      cycle(1'b0, 32'h0);
      if (pwm_out) highs++;
      if (pwm_out && !prev) rises++;
      prev = pwm_out;
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int h, r;
    rst_n = 1'b0;
    wr_en = 1'b0;
    wr_data = 32'h0;
    m_run = 0; m_commit = 0; m_step = 0; m_thr = 0;
    a_step = 0; a_thr = 0; m_acc = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) cycle(1'b0, 32'h0);
    check("R1 reset readback", rd_data, 32'h0);
    check("R1 reset output", {31'h0, pwm_out}, 32'h0);

    // R2: all bits written, reserved bits read zero
    cycle(1'b1, 32'hFFFF_FFFF);
    check("R2 reserved bits zero", rd_data, 32'hC0FF_FFFF);
    cycle(1'b1, 32'h0000_0000);
    check("R2 cleared word", rd_data, 32'h0);

    // R5/R4: commit while stopped loads next clock and self-clears
    cycle(1'b1, 32'h4040_0080);
    check("R4 commit pending", rd_data, 32'h4040_0080);
    cycle(1'b0, 32'h0);
    check("R5 stopped load clears commit", rd_data, 32'h0040_0080);

    // R6/R7: step 0x4000 thr 0x80 -> period 4, half high
    cycle(1'b1, 32'h8040_0080);
    check("R8 starts from zero low", {31'h0, pwm_out}, 32'h0);
    run_count(64, h, r);
    check("R7 highs step 0x4000", h, 32);
    check("R6 rises step 0x4000", r, 16);

    // R3: write without commit leaves waveform alone
    cycle(1'b1, 32'h8080_00C0);
    check("R2 staged readback", rd_data, 32'h8080_00C0);
    run_count(64, h, r);
    check("R3 highs unchanged", h, 32);
    check("R3 rises unchanged", r, 16);

    // R4/R3: commit while running waits for the carry
    cycle(1'b1, 32'hC080_0080);
    check("R4 commit held until boundary", rd_data, 32'hC080_0080);
    repeat (8) cycle(1'b0, 32'h0);
    check("R4 commit self-cleared", rd_data, 32'h8080_0080);
    run_count(64, h, r);
    check("R6 highs step 0x8000", h, 32);
    check("R6 rises step 0x8000", r, 32);

    // R8: stop forces low
    cycle(1'b1, 32'h0080_0080);
    run_count(16, h, r);
    check("R8 stopped highs", h, 0);

    // R7: threshold zero is always high, starting at once
    cycle(1'b1, 32'h4080_0000);
    cycle(1'b0, 32'h0);
    cycle(1'b1, 32'h8080_0000);
    check("R7 threshold zero first cycle", {31'h0, pwm_out}, 32'h1);
    run_count(32, h, r);
    check("R7 threshold zero highs", h, 32);

    // R6: step 0x8002, non-integer period, model compared every clock
    cycle(1'b1, 32'hC080_0280);
    run_count(60, h, r);
    cycle(1'b1, 32'h0);
    check("R8 stopped again", {31'h0, pwm_out}, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule